// File: doc/BRIEF.md
# Destination Address Filter

This block sits behind a receive deserializer and looks at the destination field of each incoming frame, one byte per accepted strobe. It decides whether the frame belongs to this station. The field is the first six bytes after a frame-start pulse. Three rules cover it: an exact match against six programmed station bytes, the reserved all-ones broadcast address, and a hash filter for other group (multicast) addresses. One cycle after the sixth byte the block gives a one-cycle verdict. A rejection also raises a request to drop whatever has been buffered for the frame.

The hash is a CRC-32 over the six address bytes, taken in the same bit order as on the wire. Its top six bits pick one of 64 filter bits. Software fills the station bytes, the filter bits and two enable bits through a simple synchronous write port.

The control is a four-state machine. `S_IDLE` is the state after reset and waits for a frame start. `S_COLLECT` counts the address bytes. `S_DECIDE` presents the verdict for exactly one cycle. `S_DONE` ignores the rest of the frame. The transitions are:
- A frame start moves every state to `S_COLLECT`, and also restarts a collection that is already running.
- The sixth accepted byte moves `S_COLLECT` to `S_DECIDE`.
- `S_DECIDE` always leaves after one cycle, to `S_DONE`, or to `S_COLLECT` when a frame start arrives.
- `S_DONE` waits for the next frame start.

Top module: `daf_filter`

## Requirements
- R1: After reset the outputs `decision_valid`, `accept` and `fifo_clear` are low, and every configuration register is zero. An all-zero unicast address is therefore accepted and broadcast is rejected.
- R2: An address whose first byte has bit 0 equal to 0 is unicast. It is accepted only if received byte k (k = 0 first) equals station register k (write address k, k = 0..5). A mismatch in any single byte rejects it.
- R3: The all-ones address (six bytes of 0xFF) is accepted if, and only if, control bit 0 (write address 14) is set.
- R4: An address whose first byte has bit 0 equal to 1 and that is not all ones is accepted only when control bit 1 (write address 14) is set and the filter bit chosen by its hash index is 1. Filter bit n sits at write address 6 + n/8, bit n%8.
- R5: The hash index is bits 31..26 of a CRC-32 register. The register uses polynomial 0x04C11DB7, is preset to all ones, and has no final inversion. The six address bytes are fed in, each byte least significant bit first.
- R6: `decision_valid` is high for exactly one cycle: the cycle after the clock edge that takes the sixth byte. Bytes after that are ignored until the next frame start.
- R7: `fifo_clear` is high exactly when `decision_valid` is high with a reject, and `accept` is never high together with it.
- R8: `frame_start` clears the byte count and the match state, including partway through an address. A byte strobed in the same cycle as `frame_start` is not counted.
- R9: Cycles with `byte_valid` low do not advance the byte count, so gaps between address bytes leave the verdict unchanged.
- R10: A write to address 15 changes no filtering behaviour.
- R11: Bytes strobed after reset and before any frame start are ignored and produce no verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse marking a new frame |
| byte_valid | input | 1 | Strobe for `byte_data` |
| byte_data | input | 8 | Received byte |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 4 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| decision_valid | output | 1 | Verdict is present this cycle |
| accept | output | 1 | Frame accepted |
| fifo_clear | output | 1 | Frame rejected; drop buffered bytes |

## Verification
A table of addresses is run against one fixed configuration. It holds an exact station match, a mismatch in the first, a middle and the last byte, broadcast, and several group addresses whose outcome comes from an independent reflected-form CRC model. This separates the per-byte compare from the group/broadcast paths. Directed frames then switch each enable off to isolate it. The filter array is loaded with only the expected index set, and then with every bit except it, which pins down the hash index. Byte gaps, a restart partway through an address, a byte that coincides with frame start, and stray bytes outside collection show that the counting logic responds to strobes only in the states where it should.

// File: rtl/daf_pkg.sv
package daf_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_COLLECT,
        S_DECIDE,
        S_DONE
    } daf_state_e;

    localparam int          CRC_W    = 32;
    localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

    // One byte into a left-shifting CRC register, data taken LSB first.
    function automatic logic [CRC_W-1:0] crc_step_byte(input logic [CRC_W-1:0] cur,
                                                       input logic [7:0]       din);
        logic [CRC_W-1:0] r;
        r = cur;
        for (int i = 0; i < 8; i++) begin
            if (r[CRC_W-1] ^ din[i])
                r = {r[CRC_W-2:0], 1'b0} ^ CRC_POLY;
            else
                r = {r[CRC_W-2:0], 1'b0};
        end
        return r;
    endfunction

endpackage

// File: rtl/daf_cfg_regs.sv
module daf_cfg_regs #(
    parameter int ADDR_BYTES  = 6,
    parameter int FILTER_REGS = 8,
    parameter int CFG_AW      = 4,
    localparam int FILTER_BITS = FILTER_REGS * 8,
    localparam int CTRL_ADDR   = ADDR_BYTES + FILTER_REGS
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [CFG_AW-1:0]            addr,
    input  logic [7:0]                   wdata,
    output logic [ADDR_BYTES-1:0][7:0]   station,
    output logic [FILTER_BITS-1:0]       filter,
    output logic                         bcast_en,
    output logic                         mcast_en
);

    logic [7:0] station_q [ADDR_BYTES];
    logic [7:0] filter_q  [FILTER_REGS];
    logic [1:0] ctrl_q;

    for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_station
        always_ff @(posedge clk) begin
            if (!rst_n)
                station_q[i] <= '0;
            else if (we && addr == CFG_AW'(i))
                station_q[i] <= wdata;
        end
        assign station[i] = station_q[i];
    end

    for (genvar j = 0; j < FILTER_REGS; j++) begin : g_filter
        always_ff @(posedge clk) begin
            if (!rst_n)
                filter_q[j] <= '0;
            else if (we && addr == CFG_AW'(ADDR_BYTES + j))
                filter_q[j] <= wdata;
        end
        assign filter[8*j +: 8] = filter_q[j];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (we && addr == CFG_AW'(CTRL_ADDR))
            ctrl_q <= wdata[1:0];
    end

    assign bcast_en = ctrl_q[0];
    assign mcast_en = ctrl_q[1];

endmodule

// File: rtl/daf_hash.sv
module daf_hash
    import daf_pkg::*;
#(
    parameter int HASH_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              take,
    input  logic [7:0]        din,
    output logic [HASH_W-1:0] index
);

    logic [CRC_W-1:0] crc_q;

    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            crc_q <= CRC_SEED;
        else if (take)
            crc_q <= crc_step_byte(crc_q, din);
    end

    assign index = crc_q[CRC_W-1 -: HASH_W];

endmodule

// File: rtl/daf_matcher.sv
module daf_matcher #(
    parameter int ADDR_BYTES = 6,
    parameter int IDX_W      = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       restart,
    input  logic                       take,
    input  logic [IDX_W-1:0]           idx,
    input  logic [7:0]                 din,
    input  logic [ADDR_BYTES-1:0][7:0] station,
    output logic                       station_hit,
    output logic                       all_ones,
    output logic                       group
);

    logic [7:0] ref_byte;

    always_comb begin
        ref_byte = '0;
        for (int k = 0; k < ADDR_BYTES; k++)
            if (idx == IDX_W'(k))
                ref_byte = station[k];
    end

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            station_hit <= 1'b1;
            all_ones    <= 1'b1;
            group       <= 1'b0;
        end else if (take) begin
            station_hit <= station_hit & (din == ref_byte);
            all_ones    <= all_ones & (&din);
            if (idx == '0)
                group <= din[0];
        end
    end

endmodule

// File: rtl/daf_filter.sv
module daf_filter
    import daf_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int HASH_W     = 6,
    localparam int FILTER_BITS = 1 << HASH_W,
    localparam int FILTER_REGS = FILTER_BITS / 8,
    localparam int CFG_AW      = $clog2(ADDR_BYTES + FILTER_REGS + 1),
    localparam int IDX_W       = $clog2(ADDR_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic              decision_valid,
    output logic              accept,
    output logic              fifo_clear
);

    daf_state_e state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic take, last_byte, verdict;

    logic [ADDR_BYTES-1:0][7:0] station;
    logic [FILTER_BITS-1:0]     filter;
    logic                       bcast_en, mcast_en;
    logic [HASH_W-1:0]          hash_idx;
    logic                       phys_flag, ones_flag, grp_flag;

    assign take      = (state_q == S_COLLECT) && byte_valid && !frame_start;
    assign last_byte = (idx_q == IDX_W'(ADDR_BYTES - 1));

    daf_cfg_regs #(
        .ADDR_BYTES (ADDR_BYTES),
        .FILTER_REGS(FILTER_REGS),
        .CFG_AW     (CFG_AW)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .station (station),
        .filter  (filter),
        .bcast_en(bcast_en),
        .mcast_en(mcast_en)
    );

    daf_hash #(.HASH_W(HASH_W)) u_hash (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(frame_start),
        .take   (take),
        .din    (byte_data),
        .index  (hash_idx)
    );

    daf_matcher #(.ADDR_BYTES(ADDR_BYTES), .IDX_W(IDX_W)) u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (frame_start),
        .take       (take),
        .idx        (idx_q),
        .din        (byte_data),
        .station    (station),
        .station_hit(phys_flag),
        .all_ones   (ones_flag),
        .group      (grp_flag)
    );

    // State register and byte counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (frame_start)
                idx_q <= '0;
            else if (take)
                idx_q <= idx_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (frame_start) state_d = S_COLLECT;
            S_COLLECT: begin
                if (frame_start)
                    state_d = S_COLLECT;
                else if (take && last_byte)
                    state_d = S_DECIDE;
            end
            S_DECIDE:  state_d = frame_start ? S_COLLECT : S_DONE;
            S_DONE:    if (frame_start) state_d = S_COLLECT;
        endcase
    end

    // Outputs
    always_comb begin
        if (grp_flag)
            verdict = ones_flag ? bcast_en : (mcast_en & filter[hash_idx]);
        else
            verdict = phys_flag;
        decision_valid = (state_q == S_DECIDE);
        accept         = decision_valid & verdict;
        fifo_clear     = decision_valid & ~verdict;
    end

endmodule

// File: rtl/daf_filter_chk.sv
module daf_filter_chk (
    input logic clk,
    input logic rst_n,
    input logic frame_start,
    input logic byte_valid,
    input logic decision_valid,
    input logic accept,
    input logic fifo_clear,
    input logic grp_flag,
    input logic ones_flag,
    input logic phys_flag,
    input logic bcast_en
);

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        decision_valid |=> !decision_valid);

    a_r6_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        decision_valid |-> $past(byte_valid));

    a_r8_start_no_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !decision_valid);

    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept && fifo_clear));

    a_r7_clear_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_clear || accept) |-> decision_valid);

    a_r2_unicast_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !grp_flag) |-> phys_flag);

    a_r3_bcast_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (decision_valid && grp_flag && ones_flag && !bcast_en) |-> fifo_clear);

endmodule

bind daf_filter daf_filter_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_start   (frame_start),
    .byte_valid    (byte_valid),
    .decision_valid(decision_valid),
    .accept        (accept),
    .fifo_clear    (fifo_clear),
    .grp_flag      (grp_flag),
    .ones_flag     (ones_flag),
    .phys_flag     (phys_flag),
    .bcast_en      (bcast_en)
);

// File: tb/daf_filter_test.sv
module daf_filter_test;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 10;
    localparam logic [47:0] STATION = 48'h021A_3B4C_5D6E;
    localparam logic [47:0] MC_A    = 48'h0100_5E00_0001;
    localparam logic [47:0] MC_B    = 48'h0100_5E00_00FB;
    // {kind, address}: kind 0 reject, 1 accept, 2 decided by hash model
    localparam logic [49:0] VECS [NV] = '{
        {2'd1, 48'h021A_3B4C_5D6E},
        {2'd0, 48'h021A_3B4C_5D6F},
        {2'd0, 48'h001A_3B4C_5D6E},
        {2'd0, 48'h021A_3B00_5D6E},
        {2'd1, 48'hFFFF_FFFF_FFFF},
        {2'd2, 48'hFFFF_FFFF_FFFE},
        {2'd2, 48'h0100_5E00_0001},
        {2'd2, 48'h0100_5E00_0002},
        {2'd2, 48'h3333_0000_0001},
        {2'd0, 48'h0E00_0000_0000}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_start = 1'b0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = '0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       decision_valid, accept, fifo_clear;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;
    logic [63:0] fmodel = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    daf_filter uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_start   (frame_start),
        .byte_valid    (byte_valid),
        .byte_data     (byte_data),
        .cfg_we        (cfg_we),
        .cfg_addr      (cfg_addr),
        .cfg_wdata     (cfg_wdata),
        .decision_valid(decision_valid),
        .accept        (accept),
        .fifo_clear    (fifo_clear)
    );

    // Reflected-register form of the hash definition
    function automatic logic [5:0] hash_of(input logic [47:0] a);
        logic [31:0] r;
        logic [5:0]  h;
        r = 32'hFFFF_FFFF;
        for (int k = 0; k < 6; k++) begin
            logic [7:0] b;
            b = a[47 - 8*k -: 8];
            for (int i = 0; i < 8; i++) begin
                logic fb;
                fb = r[0] ^ b[i];
                r = r >> 1;
                if (fb) r = r ^ 32'hEDB8_8320;
            end
        end
        for (int j = 0; j < 6; j++) h[5-j] = r[j];
        return h;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic load_filter();
        for (int j = 0; j < 8; j++) wr(4'(6 + j), fmodel[8*j +: 8]);
    endtask

    task automatic load_station(input logic [47:0] s);
        for (int k = 0; k < 6; k++) wr(4'(k), s[47 - 8*k -: 8]);
    endtask

    // Frame start, then six bytes with 'gap' idle cycles between them.
    // Returns at the negedge of the verdict cycle.
    task automatic send(input logic [47:0] a, input int gap);
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        for (int k = 0; k < 6; k++) begin
            byte_valid = 1'b1; byte_data = a[47 - 8*k -: 8];
            @(negedge clk);
            byte_valid = 1'b0;
            if (k < 5) repeat (gap) @(negedge clk);
        end
    endtask

    task automatic expect_verdict(input string req, input bit exp);
        chk(decision_valid === 1'b1, req, 32'(decision_valid), 1);
        chk(accept === exp, req, 32'(accept), 32'(exp));
        chk(fifo_clear === !exp, req, 32'(fifo_clear), 32'(!exp));
        @(negedge clk);
        chk(decision_valid === 1'b0, {req, " R6 pulse"}, 32'(decision_valid), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(decision_valid === 1'b0 && accept === 1'b0 && fifo_clear === 1'b0,
            "R1 outputs in reset", {29'd0, decision_valid, accept, fifo_clear}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(decision_valid === 1'b0, "R1 outputs after reset", 32'(decision_valid), 0);

        // R11: bytes before any frame start produce nothing
        for (int k = 0; k < 8; k++) begin
            byte_valid = 1'b1; byte_data = 8'h00;
            @(negedge clk);
            chk(decision_valid === 1'b0, "R11 idle bytes", 32'(decision_valid), 0);
        end
        byte_valid = 1'b0;

        // R1: zero config accepts all-zero unicast, rejects broadcast
        send(48'h0, 0);
        expect_verdict("R1 zero station", 1'b1);
        send(48'hFFFF_FFFF_FFFF, 0);
        expect_verdict("R1 R3 bcast off at reset", 1'b0);

        // Table configuration
        load_station(STATION);
        fmodel = '0;
        fmodel[hash_of(MC_A)] = 1'b1;
        load_filter();
        wr(4'd14, 8'h03);

        for (int v = 0; v < NV; v++) begin
            logic [1:0] kind;
            logic [47:0] a;
            bit e;
            kind = VECS[v][49:48];
            a = VECS[v][47:0];
            e = (kind == 2'd2) ? fmodel[hash_of(a)] : kind[0];
            send(a, 0);
            expect_verdict($sformatf("R2 R3 R4 vector %0d", v), e);
        end

        // R3: broadcast disabled
        wr(4'd14, 8'h02);
        send(48'hFFFF_FFFF_FFFF, 0);
        expect_verdict("R3 bcast disabled R7", 1'b0);

        // R4: multicast disabled, filter bit set
        wr(4'd14, 8'h01);
        send(MC_A, 0);
        expect_verdict("R4 mcast disabled", 1'b0);

        // R5: only the hashed bit matters
        wr(4'd14, 8'h03);
        fmodel = '0;
        fmodel[hash_of(MC_B)] = 1'b1;
        load_filter();
        send(MC_B, 0);
        expect_verdict("R5 single bit set", 1'b1);
        fmodel = '1;
        fmodel[hash_of(MC_B)] = 1'b0;
        load_filter();
        send(MC_B, 0);
        expect_verdict("R5 all but hashed bit", 1'b0);

        // R9: gaps between bytes
        send(STATION, 3);
        expect_verdict("R9 gapped unicast", 1'b1);

        // R8: restart partway through
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        for (int k = 0; k < 3; k++) begin
            byte_valid = 1'b1; byte_data = 8'hAA;
            @(negedge clk);
        end
        byte_valid = 1'b0;
        send(STATION, 0);
        expect_verdict("R8 restart", 1'b1);

        // R8: byte coinciding with frame start is not counted
        @(negedge clk);
        frame_start = 1'b1; byte_valid = 1'b1; byte_data = 8'h55;
        @(negedge clk);
        frame_start = 1'b0;
        for (int k = 0; k < 6; k++) begin
            byte_valid = 1'b1; byte_data = STATION[47 - 8*k -: 8];
            @(negedge clk);
        end
        byte_valid = 1'b0;
        expect_verdict("R8 coincident byte", 1'b1);

        // R6: bytes after the verdict are ignored
        for (int k = 0; k < 7; k++) begin
            byte_valid = 1'b1; byte_data = 8'hFF;
            @(negedge clk);
            chk(decision_valid === 1'b0, "R6 trailing bytes", 32'(decision_valid), 0);
        end
        byte_valid = 1'b0;

        // R10: unmapped write
        wr(4'd15, 8'hFF);
        send(STATION, 0);
        expect_verdict("R10 unmapped write unicast", 1'b1);
        send(MC_B, 0);
        expect_verdict("R10 unmapped write multicast", 1'b0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule